// File: doc/BRIEF.md
# Two-Wire Bus Memory Slave Controller

This block puts a byte-addressed memory on a two-wire serial bus as a slave. Both bus lines are sampled on the system clock through a synchroniser. Edges are found on the synchronised values, and from them the block recognises START and STOP conditions. It collects the device byte and compares it with a fixed 4-bit type code and a 3-bit strap. It answers on SDA through an active-high pull-low enable, so the pin itself stays open-drain outside the block.

The memory side sees pulses with data attached, each valid for one cycle. `wa_load` carries a 16-bit word address built from the two address bytes of a write. `wr_valid` carries one received data byte. `rd_req` asks for the next byte to send, and the memory must present that byte on `rd_data` in the following cycle. The memory side keeps its own pointer and advances it on `wr_valid` and on `rd_req`. A current-address read therefore continues from where the last access stopped. While the `busy` input is high, the block does not acknowledge its own device byte, so a host can poll until a write cycle is complete.

States: `ST_IDLE` (bus ignored), `ST_DEV` (device byte), `ST_DEV_ACK`, `ST_AHI`/`ST_AHI_ACK` (high address byte), `ST_ALO`/`ST_ALO_ACK` (low address byte), `ST_WDAT`/`ST_WDAT_ACK` (write data), `ST_RDAT` (byte out) and `ST_RDAT_ACK` (host acknowledge). The transitions are:
- A START moves any state to `ST_DEV`, and a STOP moves any state to `ST_IDLE`.
- From `ST_DEV`, a hit goes to `ST_DEV_ACK` and a miss goes to `ST_IDLE`.
- `ST_DEV_ACK` goes to `ST_RDAT` for a read, or to `ST_AHI` for a write.
- Each receive state goes to its ACK state after eight bits.
- `ST_AHI_ACK` goes to `ST_ALO`, `ST_ALO_ACK` goes to `ST_WDAT`, and `ST_WDAT_ACK` goes back to `ST_WDAT`.
- `ST_RDAT` goes to `ST_RDAT_ACK` after eight bits. `ST_RDAT_ACK` goes back to `ST_RDAT` on a host ACK, or to `ST_IDLE` on a host NACK.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset, `sda_low` is 0, and `wr_valid`, `wa_load` and `rd_req` stay 0 while the bus is idle.
- R2: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. Until a START is seen, bus traffic causes no acknowledge and no memory-side pulse.
- R3: The device byte is sent MSB first. Its bits [7:4] must be 1010 and its bits [3:1] must equal `strap_addr`. Bit 0 selects the operation: 1 = read, 0 = write. A mismatch gets no acknowledge, and the block ignores the bus until the next START.
- R4: Every accepted byte (device byte, address bytes, write data) is acknowledged by driving SDA low for the whole ninth SCL clock.
- R5: In a write, the first two bytes after the device byte form the word address, high byte first. When the second byte completes, `wa_load` pulses once with `wa_value` = {high, low}. Every later byte pulses `wr_valid` once with that byte on `wr_data`.
- R6: While `busy` is 1 when the device byte completes, that byte is not acknowledged and no memory-side pulse follows. Once `busy` is 0, the same byte is acknowledged.
- R7: In a read, `rd_req` pulses once at the ninth clock of the device byte, and once more at each ninth clock where the host acknowledges. The byte from `rd_data` goes out MSB first. After a host NACK, the block releases SDA and ignores the bus until the next START.
- R8: A write-mode device byte and two address bytes, then a repeated START and a read-mode device byte, give data starting at the loaded address.
- R9: A START in the middle of a byte restarts device-byte reception. A STOP in the middle of a byte returns the block to idle and produces no memory-side pulse.
- R10: `sda_low` changes only while the synchronised SCL is low, except on the cycle after a START or STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | SCL level from the bus |
| sda_in | input | 1 | SDA level from the bus |
| sda_low | output | 1 | 1 pulls SDA low (open-drain enable) |
| strap_addr | input | 3 | Device select strap, compared with device byte bits [3:1] |
| busy | input | 1 | Memory write cycle in progress; blocks the address acknowledge |
| wa_load | output | 1 | One-cycle pulse: word address received |
| wa_value | output | 16 | Word address, valid with `wa_load` |
| wr_valid | output | 1 | One-cycle pulse: data byte received |
| wr_data | output | 8 | Data byte, valid with `wr_valid` |
| rd_req | output | 1 | One-cycle pulse: next byte to send is wanted |
| rd_data | input | 8 | Byte to send, valid the cycle after `rd_req` |

## Verification
The bench goes after these corner cases:
- Bus traffic before any START. A design that watches the bus while idle would acknowledge this traffic.
- A strap mismatch. A design that compares the device byte badly would acknowledge a foreign device byte.
- Polling while busy. If the busy gate were missing, the host would get an acknowledge during a write cycle.
- Sequential reads that end in a NACK. Bytes sent after that NACK must get no acknowledge; a design that kept transmitting would answer them or issue an extra `rd_req`.
- A START in the middle of an address byte, and a STOP in the middle of an address byte. A design that did not abort would produce a stray word-address load or lose the repeated read.

// File: rtl/twm_pkg.sv
package twm_pkg;
    typedef enum logic [3:0] {
        ST_IDLE,
        ST_DEV,
        ST_DEV_ACK,
        ST_AHI,
        ST_AHI_ACK,
        ST_ALO,
        ST_ALO_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_RDAT,
        ST_RDAT_ACK
    } twm_state_e;

    localparam logic [3:0] DEV_TYPE_CODE = 4'b1010;
endpackage

// File: rtl/twm_line_sync.sv
module twm_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_raw,
    input  logic sda_raw,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[STAGES-2:0], scl_raw};
            sda_pipe <= {sda_pipe[STAGES-2:0], sda_raw};
            scl_q    <= scl_pipe[STAGES-1];
            sda_q    <= sda_pipe[STAGES-1];
        end
    end

    assign scl_s     = scl_pipe[STAGES-1];
    assign sda_s     = sda_pipe[STAGES-1];
    assign scl_rise  = scl_s && !scl_q;
    assign scl_fall  = !scl_s && scl_q;
    assign start_det = scl_s && scl_q && sda_q && !sda_s;
    assign stop_det  = scl_s && scl_q && !sda_q && sda_s;
endmodule

// File: rtl/twm_rx_shift.sv
module twm_rx_shift #(
    parameter int WIDTH = 8,
    localparam int CW = $clog2(WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             shift_en,
    input  logic             bit_in,
    output logic [WIDTH-1:0] data,
    output logic             full
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            cnt  <= '0;
        end else if (clear) begin
            cnt <= '0;
        end else if (shift_en) begin
            data <= {data[WIDTH-2:0], bit_in};
            cnt  <= cnt + 1'b1;
        end
    end

    assign full = (cnt == CW'(WIDTH));
endmodule

// File: rtl/twm_tx_shift.sv
module twm_tx_shift #(
    parameter int WIDTH = 8,
    localparam int CW = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift_en,
    output logic             msb,
    output logic             last
);
    logic [WIDTH-1:0] sreg;
    logic [CW-1:0]    cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg <= '1;
            cnt  <= '0;
        end else if (load) begin
            sreg <= load_val;
            cnt  <= '0;
        end else if (shift_en) begin
            sreg <= {sreg[WIDTH-2:0], 1'b1};
            cnt  <= cnt + 1'b1;
        end
    end

    assign msb  = sreg[WIDTH-1];
    assign last = (cnt == CW'(WIDTH - 1));
endmodule

// File: rtl/twowire_mem_slave.sv
module twowire_mem_slave
    import twm_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2,
    parameter int STRAP_W     = 3,
    localparam int WA_W       = 2 * DATA_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_in,
    input  logic               sda_in,
    output logic               sda_low,
    input  logic [STRAP_W-1:0] strap_addr,
    input  logic               busy,
    output logic               wa_load,
    output logic [WA_W-1:0]    wa_value,
    output logic               wr_valid,
    output logic [DATA_W-1:0]  wr_data,
    output logic               rd_req,
    input  logic [DATA_W-1:0]  rd_data
);
    twm_state_e state, nxt;

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic [DATA_W-1:0] rx_byte, wa_hi_q;
    logic rx_full, rx_clear, rx_shift;
    logic tx_msb, tx_last, tx_shift, rd_pend, rw_q;
    logic addr_hit, byte_done;

    twm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_raw(scl_in), .sda_raw(sda_in),
        .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    twm_rx_shift #(.WIDTH(DATA_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .clear(rx_clear), .shift_en(rx_shift),
        .bit_in(sda_s), .data(rx_byte), .full(rx_full)
    );

    twm_tx_shift #(.WIDTH(DATA_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .load(rd_pend), .load_val(rd_data),
        .shift_en(tx_shift), .msb(tx_msb), .last(tx_last)
    );

    assign byte_done = scl_fall && rx_full;
    assign addr_hit  = (rx_byte[DATA_W-1 -: 4] == DEV_TYPE_CODE)
                    && (rx_byte[STRAP_W:1] == strap_addr) && !busy;
    assign rx_shift  = scl_rise && (state inside {ST_DEV, ST_AHI, ST_ALO, ST_WDAT});
    assign rx_clear  = start_det || byte_done;
    assign tx_shift  = scl_fall && (state == ST_RDAT) && !tx_last;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // side registers: direction, high address byte, read load strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rw_q    <= 1'b0;
            wa_hi_q <= '0;
            rd_pend <= 1'b0;
        end else begin
            rd_pend <= rd_req;
            if (state == ST_DEV && byte_done) rw_q <= rx_byte[0];
            if (state == ST_AHI && byte_done) wa_hi_q <= rx_byte;
        end
    end

    // next state
    always_comb begin
        nxt = state;
        if (start_det) begin
            nxt = ST_DEV;
        end else if (stop_det) begin
            nxt = ST_IDLE;
        end else begin
            unique case (state)
                ST_IDLE:     nxt = ST_IDLE;
                ST_DEV:      if (byte_done) nxt = addr_hit ? ST_DEV_ACK : ST_IDLE;
                ST_DEV_ACK:  if (scl_fall) nxt = rw_q ? ST_RDAT : ST_AHI;
                ST_AHI:      if (byte_done) nxt = ST_AHI_ACK;
                ST_AHI_ACK:  if (scl_fall) nxt = ST_ALO;
                ST_ALO:      if (byte_done) nxt = ST_ALO_ACK;
                ST_ALO_ACK:  if (scl_fall) nxt = ST_WDAT;
                ST_WDAT:     if (byte_done) nxt = ST_WDAT_ACK;
                ST_WDAT_ACK: if (scl_fall) nxt = ST_WDAT;
                ST_RDAT:     if (scl_fall && tx_last) nxt = ST_RDAT_ACK;
                ST_RDAT_ACK: begin
                    if (scl_rise && sda_s) nxt = ST_IDLE;
                    else if (scl_fall)     nxt = ST_RDAT;
                end
                default:     nxt = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        sda_low  = (state inside {ST_DEV_ACK, ST_AHI_ACK, ST_ALO_ACK, ST_WDAT_ACK})
                || (state == ST_RDAT && !tx_msb);
        wa_load  = (state == ST_ALO) && byte_done && !start_det && !stop_det;
        wa_value = {wa_hi_q, rx_byte};
        wr_valid = (state == ST_WDAT) && byte_done && !start_det && !stop_det;
        wr_data  = rx_byte;
        rd_req   = scl_rise && (((state == ST_DEV_ACK) && rw_q)
                             || ((state == ST_RDAT_ACK) && !sda_s));
    end
endmodule

// File: rtl/twm_checker.sv
module twm_checker
    import twm_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input twm_state_e state,
    input logic       scl_s,
    input logic       start_det,
    input logic       stop_det,
    input logic       sda_low,
    input logic       busy,
    input logic       wa_load,
    input logic       wr_valid,
    input logic       rd_req
);
    // R2: a STOP always lands in idle
    a_r2_stop_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (state == ST_IDLE));

    // R9: a START always restarts device-byte reception
    a_r9_start_to_dev: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_DEV));

    // R6: the address ACK state is never entered while busy was high
    a_r6_busy_no_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state == ST_DEV_ACK) |-> !$past(busy));

    // R10: drive changes only while SCL is low, START/STOP aside
    a_r10_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s) && !$past(start_det) && !$past(stop_det))
            |-> $stable(sda_low));

    // R5: address load and data pulse never coincide
    a_r5_one_event: assert property (@(posedge clk) disable iff (!rst_n)
        !(wa_load && wr_valid));

    // R7: a byte request lasts one cycle
    a_r7_rdreq_single: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |=> !rd_req);

    // R1: nothing is pulled or requested while idle
    a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (!sda_low && !rd_req && !wr_valid && !wa_load));
endmodule

bind twowire_mem_slave twm_checker u_chk (
    .clk(clk), .rst_n(rst_n), .state(state), .scl_s(scl_s),
    .start_det(start_det), .stop_det(stop_det), .sda_low(sda_low),
    .busy(busy), .wa_load(wa_load), .wr_valid(wr_valid), .rd_req(rd_req)
);

// File: tb/twowire_mem_slave_bench.sv
module twowire_mem_slave_bench;
    localparam int H = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_drv = 1'b1, sda_drv = 1'b1, busy = 1'b0;
    logic [2:0]  strap = 3'b101;
    logic        sda_low, wa_load, wr_valid, rd_req;
    logic [15:0] wa_value;
    logic [7:0]  wr_data, rd_data;
    wire         sda_line = sda_drv & ~sda_low;

    int checks = 0, fails = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    twowire_mem_slave u_twowire_mem_slave (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_drv), .sda_in(sda_line),
        .sda_low(sda_low), .strap_addr(strap), .busy(busy),
        .wa_load(wa_load), .wa_value(wa_value), .wr_valid(wr_valid),
        .wr_data(wr_data), .rd_req(rd_req), .rd_data(rd_data)
    );

    // memory-side model
    logic [7:0]  mem [0:255];
    logic [7:0]  exp_mem [0:255];
    logic [15:0] ptr;
    initial for (int i = 0; i < 256; i++) begin
        mem[i] = 8'(i * 7 + 1);
        exp_mem[i] = 8'(i * 7 + 1);
    end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr <= '0;
            rd_data <= '0;
        end else begin
            if (wa_load) ptr <= wa_value;
            if (wr_valid) begin
                mem[ptr[7:0]] <= wr_data;
                ptr <= ptr + 1'b1;
            end
            if (rd_req) begin
                rd_data <= mem[ptr[7:0]];
                ptr <= ptr + 1'b1;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard: {is_addr, value}
    logic [16:0] exp_q[$];

    always @(negedge clk) begin
        if (rst_n && (wa_load || wr_valid)) begin
            if (exp_q.size() == 0) begin
                check(0, wa_load ? "R5/R9 unexpected wa_load" : "R5 unexpected wr_valid",
                      wa_load ? int'(wa_value) : int'(wr_data), 0);
            end else begin
                logic [16:0] it;
                it = exp_q.pop_front();
                if (wa_load) check(it[16] && it[15:0] == wa_value, "R5 word address",
                                   int'(wa_value), int'(it));
                else check(!it[16] && it[7:0] == wr_data, "R5 write data",
                           int'(wr_data), int'(it));
            end
        end
    end

    task automatic wcyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_drv = 1'b1; wcyc(H);
        scl_drv = 1'b1; wcyc(H);
        sda_drv = 1'b0; wcyc(H);
        scl_drv = 1'b0; wcyc(H);
    endtask

    task automatic bus_stop();
        sda_drv = 1'b0; wcyc(H);
        scl_drv = 1'b1; wcyc(H);
        sda_drv = 1'b1; wcyc(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 7; i > 7 - n; i--) begin
            sda_drv = b[i]; wcyc(H);
            scl_drv = 1'b1; wcyc(H);
            scl_drv = 1'b0; wcyc(2);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output bit acked);
        send_bits(b, 8);
        sda_drv = 1'b1; wcyc(H);
        scl_drv = 1'b1; wcyc(H / 2);
        acked = !sda_line;
        wcyc(H / 2);
        scl_drv = 1'b0; wcyc(2);
    endtask

    task automatic recv_byte(output logic [7:0] b, input bit host_ack);
        sda_drv = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            wcyc(H);
            scl_drv = 1'b1; wcyc(H / 2);
            b[i] = sda_line;
            wcyc(H / 2);
            scl_drv = 1'b0; wcyc(2);
        end
        wcyc(H);
        sda_drv = !host_ack; wcyc(H);
        scl_drv = 1'b1; wcyc(H);
        scl_drv = 1'b0; wcyc(H);
        sda_drv = 1'b1;
    endtask

    task automatic write_seq(input logic [15:0] a, input logic [7:0] d0, input logic [7:0] d1);
        bit ak;
        bus_start();
        send_byte(8'hAA, ak); check(ak, "R4 device byte ack", ak, 1);
        exp_q.push_back({1'b1, a});
        send_byte(a[15:8], ak); check(ak, "R5 high address ack", ak, 1);
        send_byte(a[7:0], ak);  check(ak, "R5 low address ack", ak, 1);
        exp_q.push_back({9'h0, d0});
        send_byte(d0, ak); check(ak, "R4 data ack", ak, 1);
        exp_q.push_back({9'h0, d1});
        send_byte(d1, ak); check(ak, "R4 data ack", ak, 1);
        exp_mem[a[7:0]] = d0;
        exp_mem[8'(a[7:0] + 1)] = d1;
        bus_stop();
    endtask

    initial begin
        bit ak;
        logic [7:0] rb;
        wcyc(4);
        check(!sda_low && !wa_load && !wr_valid && !rd_req, "R1 reset outputs", sda_low, 0);
        rst_n = 1'b1;
        wcyc(8);
        check(!sda_low, "R1 idle release", sda_low, 0);

        // R2: traffic before any START is ignored
        send_byte(8'hAA, ak); check(!ak, "R2 no ack without START", ak, 0);
        bus_stop();

        // R3: strap mismatch
        bus_start();
        send_byte(8'hA2, ak); check(!ak, "R3 strap mismatch nack", ak, 0);
        send_byte(8'hAA, ak); check(!ak, "R3 ignored after mismatch", ak, 0);
        bus_stop();

        // R5: write with two-byte address
        write_seq(16'h0010, 8'h5A, 8'hC3);

        // R6: busy suppresses address ACK
        busy = 1'b1;
        bus_start();
        send_byte(8'hAA, ak); check(!ak, "R6 busy nack", ak, 0);
        bus_stop();
        busy = 1'b0;
        bus_start();
        send_byte(8'hAA, ak); check(ak, "R6 ack after busy", ak, 1);
        bus_stop();

        // R8: random read through dummy write and repeated START
        bus_start();
        send_byte(8'hAA, ak); check(ak, "R8 dummy write ack", ak, 1);
        exp_q.push_back({1'b1, 16'h000F});
        send_byte(8'h00, ak);
        send_byte(8'h0F, ak); check(ak, "R8 address ack", ak, 1);
        bus_start();
        send_byte(8'hAB, ak); check(ak, "R8 read device ack", ak, 1);
        recv_byte(rb, 1'b1); check(rb == exp_mem[8'h0F], "R8 first byte", rb, exp_mem[8'h0F]);
        recv_byte(rb, 1'b1); check(rb == 8'h5A, "R7 sequential byte", rb, 8'h5A);
        recv_byte(rb, 1'b0); check(rb == 8'hC3, "R7 last byte", rb, 8'hC3);
        // R7: after NACK, no ACK and no further requests
        send_byte(8'hAA, ak); check(!ak, "R7 ignored after host nack", ak, 0);
        bus_stop();

        // R7: current-address read continues at 0x12
        bus_start();
        send_byte(8'hAB, ak); check(ak, "R7 current read ack", ak, 1);
        recv_byte(rb, 1'b0); check(rb == exp_mem[8'h12], "R7 current address byte", rb, exp_mem[8'h12]);
        bus_stop();

        // R9: START mid-byte restarts device reception
        bus_start();
        send_byte(8'hAA, ak);
        send_bits(8'h00, 4);
        bus_start();
        send_byte(8'hAB, ak); check(ak, "R9 restart ack", ak, 1);
        recv_byte(rb, 1'b0); check(rb == exp_mem[8'h13], "R9 read after restart", rb, exp_mem[8'h13]);
        bus_stop();

        // R9: STOP mid-byte goes idle without pulses
        bus_start();
        send_byte(8'hAA, ak);
        send_byte(8'h00, ak);
        send_bits(8'h40, 3);
        scl_drv = 1'b0;
        bus_stop();
        send_byte(8'hAA, ak); check(!ak, "R9 idle after mid-byte STOP", ak, 0);
        bus_stop();

        // second write to check data path again
        write_seq(16'h0030, 8'h01, 8'hFE);

        wcyc(20);
        check(exp_q.size() == 0, "R5 all expected events seen", exp_q.size(), 0);
        check(!sda_low, "R1 released at end", sda_low, 0);
        if (!finished) begin
            finished = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end
endmodule